// File: doc/BRIEF.md
# Prioritized Interrupt Level Controller

This block decides when the processor core leaves the current instruction stream to service an interrupt. Each of several sources presents a 3-bit request level, where 0 means idle and 1 to 7 are increasing urgency, plus an 8-bit vector number. The controller finds the most urgent pending request. It compares that level with the 3-bit mask field of the processor status word, which it holds itself. It accepts the request only at an instruction boundary. On acceptance it raises the mask to the accepted level and sets the supervisor bit. It also reports the status word as it stood before the change, so the core can push it, and it gives the byte address of the vector-table entry to fetch.

Level 7 cannot be masked. It is recognised on its arrival rather than on its presence, so a source that keeps level 7 asserted is serviced once. The core can overwrite the status word, as a privileged move to the status word would do. It can also restore a saved word when it leaves an exception handler. Either of these actions suppresses acceptance in the same cycle.

Status word layout (only these bits exist; all others read 0): bit 15 trace, bit 13 supervisor, bits 10:8 interrupt mask, bits 4:0 the flags X, N, Z, V, C from high to low.

Top module: `irq_level_ctrl`

## Requirements
- R1: After a synchronous active-low reset the status word is 0x2700 (supervisor set, mask 7) and `take` is 0.
- R2: Among requesting sources the highest level wins; at equal level the lowest-numbered source wins, and its vector is the one reported.
- R3: A winning level from 1 to 6 is accepted only when it is strictly greater than the current mask; a level equal to or below the mask produces no `take` and leaves the status word unchanged.
- R4: Level 7 is accepted whatever the mask, but only once per arrival: after acceptance it is not accepted again until some cycle has no source at level 7. An arrival not yet accepted stays pending.
- R5: An acceptance in cycle k gives, after the edge ending k: `take` high for one cycle, `take_level` equal to the level, mask field equal to the level, supervisor bit set, trace and flags unchanged, and `take_saved_sr` equal to the status word before the edge.
- R6: `take_vec_addr` is the winning vector number times four, a 10-bit address in 0x000..0x3FC.
- R7: `exc_return` loads `exc_return_sr` into the status word. It takes precedence over `sr_load`, which loads `sr_load_data`. In a cycle with either strobe no request is accepted.
- R8: Status word bits 14, 12, 11, 7, 6 and 5 always read 0, whatever is loaded.
- R9: With `boundary` low no request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_level | input | N_SRC*3 | Request level per source, source i in bits [3i+2:3i], 0 = idle |
| src_vector | input | N_SRC*8 | Vector number per source, source i in bits [8i+7:8i] |
| boundary | input | 1 | Core is at an instruction boundary and may be interrupted |
| sr_load | input | 1 | Write `sr_load_data` into the status word |
| sr_load_data | input | 16 | Value for a status word write |
| exc_return | input | 1 | Return-from-exception strobe: restore the status word |
| exc_return_sr | input | 16 | Saved status word popped by the core |
| status_word | output | 16 | Current processor status word |
| take | output | 1 | One-cycle pulse: an interrupt was accepted |
| take_level | output | 3 | Level of the accepted interrupt |
| take_vec_addr | output | 10 | Byte address of the vector-table entry |
| take_saved_sr | output | 16 | Status word before acceptance, to be pushed |

## Verification
The checker assumes that strobes and request levels are stable, synchronous inputs. It also assumes that `exc_return` and `sr_load` are not asserted during reset. The bench drives every input on the falling edge and holds `boundary`, both strobes and all levels low while reset is active. This keeps every edge-relative property in defined territory. Each sweep trial starts with a cycle in which no source requests. That cycle re-arms the level-7 edge detector, so an acceptance is always caused by the trial's own pattern.

// File: rtl/irq_pkg.sv
// Package irq_pkg
// Shared constants and helpers for the interrupt level controller: status
// word bit positions, implemented-bit mask, reset value and the status word
// update applied on acceptance. Assumes a 16-bit status word, 3-bit levels.
package irq_pkg;

    localparam int LVL_W     = 3;
    localparam int SR_W      = 16;
    localparam int T_BIT     = 15;
    localparam int S_BIT     = 13;
    localparam int MASK_LO   = 8;
    localparam int MASK_HI   = MASK_LO + LVL_W - 1;

    localparam logic [LVL_W-1:0] NMI_LEVEL = '1;
    localparam logic [SR_W-1:0]  SR_IMPL   = 16'hA71F;
    localparam logic [SR_W-1:0]  SR_RESET  = 16'h2700;

    // Status word after accepting a request at level lvl.
    function automatic logic [SR_W-1:0] sr_enter(input logic [SR_W-1:0] sr,
                                                 input logic [LVL_W-1:0] lvl);
        logic [SR_W-1:0] r;
        r = sr;
        r[MASK_HI:MASK_LO] = lvl;
        r[S_BIT] = 1'b1;
        return r & SR_IMPL;
    endfunction

endpackage

// File: rtl/irq_prio_enc.sv
// Module irq_prio_enc
// Finds the highest request level among N_SRC sources and the index of the
// lowest-numbered source holding it. Purely combinational; level 0 = idle.
module irq_prio_enc #(
    parameter int N_SRC = 4,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC*irq_pkg::LVL_W-1:0] src_level,
    output logic [irq_pkg::LVL_W-1:0]       best_level,
    output logic [IDX_W-1:0]                best_idx
);
    import irq_pkg::*;

    logic [LVL_W-1:0] lvl [N_SRC];

    // Split the packed level bus into one entry per source.
    for (genvar g = 0; g < N_SRC; g++) begin : g_split
        assign lvl[g] = src_level[g*LVL_W +: LVL_W];
    end

    // Scan upward; a strict compare keeps the lowest index on ties.
    always_comb begin
        best_level = '0;
        best_idx   = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (lvl[i] > best_level) begin
                best_level = lvl[i];
                best_idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_accept_gate.sv
// Module irq_accept_gate
// Decides acceptance of the winning level: levels 1..6 must exceed the mask,
// level 7 bypasses the mask but is armed only by a cycle without level 7.
// Assumes best_level comes from the priority encoder in the same cycle.
module irq_accept_gate (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [irq_pkg::LVL_W-1:0] best_level,
    input  logic [irq_pkg::LVL_W-1:0] cur_mask,
    input  logic                      boundary,
    input  logic                      blocked,
    output logic                      accept
);
    import irq_pkg::*;

    logic nmi_armed;
    logic is_nmi;

    assign is_nmi = (best_level == NMI_LEVEL);

    // Acceptance rule for the current cycle.
    always_comb begin
        if (blocked || !boundary || best_level == '0) begin
            accept = 1'b0;
        end else if (is_nmi) begin
            accept = nmi_armed;
        end else begin
            accept = (best_level > cur_mask);
        end
    end

    // Level-7 edge memory: disarm on acceptance, re-arm when level 7 is absent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_armed <= 1'b1;
        end else if (accept && is_nmi) begin
            nmi_armed <= 1'b0;
        end else if (!is_nmi) begin
            nmi_armed <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_status_reg.sv
// Module irq_status_reg
// Holds the processor status word. Priority: exception return, then a
// direct write, then acceptance. Unimplemented bits are always cleared.
module irq_status_reg (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      restore,
    input  logic [irq_pkg::SR_W-1:0]  restore_data,
    input  logic                      load,
    input  logic [irq_pkg::SR_W-1:0]  load_data,
    input  logic                      accept,
    input  logic [irq_pkg::LVL_W-1:0] accept_level,
    output logic [irq_pkg::SR_W-1:0]  sr
);
    import irq_pkg::*;

    // Status word update in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= SR_RESET;
        end else if (restore) begin
            sr <= restore_data & SR_IMPL;
        end else if (load) begin
            sr <= load_data & SR_IMPL;
        end else if (accept) begin
            sr <= sr_enter(sr, accept_level);
        end
    end
endmodule

// File: rtl/irq_level_ctrl.sv
// Module irq_level_ctrl (top)
// Prioritized interrupt level controller: encodes the highest pending level,
// gates it against the status word mask, updates the status word and reports
// the accepted level, vector-table byte address and pre-acceptance status.
// Assumes all inputs are synchronous to clk.
module irq_level_ctrl #(
    parameter int N_SRC = 4,
    parameter int VEC_W = 8,
    localparam int ADDR_W = VEC_W + 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_SRC*3-1:0]        src_level,
    input  logic [N_SRC*VEC_W-1:0]    src_vector,
    input  logic                      boundary,
    input  logic                      sr_load,
    input  logic [15:0]               sr_load_data,
    input  logic                      exc_return,
    input  logic [15:0]               exc_return_sr,
    output logic [15:0]               status_word,
    output logic                      take,
    output logic [2:0]                take_level,
    output logic [ADDR_W-1:0]         take_vec_addr,
    output logic [15:0]               take_saved_sr
);
    import irq_pkg::*;

    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic [LVL_W-1:0] best_level;
    logic [IDX_W-1:0] best_idx;
    logic [VEC_W-1:0] best_vec;
    logic             accept;
    logic             blocked;

    assign blocked  = exc_return | sr_load;
    assign best_vec = src_vector[best_idx*VEC_W +: VEC_W];

    irq_prio_enc #(.N_SRC(N_SRC)) u_enc (
        .src_level  (src_level),
        .best_level (best_level),
        .best_idx   (best_idx)
    );

    irq_accept_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .best_level (best_level),
        .cur_mask   (status_word[MASK_HI:MASK_LO]),
        .boundary   (boundary),
        .blocked    (blocked),
        .accept     (accept)
    );

    irq_status_reg u_sr (
        .clk          (clk),
        .rst_n        (rst_n),
        .restore      (exc_return),
        .restore_data (exc_return_sr),
        .load         (sr_load),
        .load_data    (sr_load_data),
        .accept       (accept),
        .accept_level (best_level),
        .sr           (status_word)
    );

    // Register the acceptance report for the core's exception sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take          <= 1'b0;
            take_level    <= '0;
            take_vec_addr <= '0;
            take_saved_sr <= '0;
        end else begin
            take <= accept;
            if (accept) begin
                take_level    <= best_level;
                take_vec_addr <= {best_vec, 2'b00};
                take_saved_sr <= status_word;
            end
        end
    end
endmodule

// File: rtl/irq_level_ctrl_chk.sv
// Module irq_level_ctrl_chk
// Property checker for irq_level_ctrl, attached by bind below. Assumes the
// strobes are low while reset is asserted.
module irq_level_ctrl_chk #(
    parameter int N_SRC = 4,
    parameter int VEC_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              boundary,
    input logic              sr_load,
    input logic              exc_return,
    input logic [15:0]       exc_return_sr,
    input logic [15:0]       status_word,
    input logic              take,
    input logic [2:0]        take_level,
    input logic [VEC_W+1:0]  take_vec_addr
);
    // R5: accepted level becomes the mask, supervisor set
    p_mask_is_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (status_word[10:8] == take_level) && status_word[13]);

    // R3: maskable levels only above the previous mask
    p_above_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_level != 3'd7) |-> (take_level > $past(status_word[10:8])));

    // R4: level 7 not taken twice back to back
    p_nmi_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_level == 3'd7) |=> !(take && take_level == 3'd7));

    // R6: vector address is word aligned
    p_vec_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (take_vec_addr[1:0] == 2'b00));

    // R9: acceptance only at a boundary
    p_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(boundary));

    // R7: return restores the word
    p_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(exc_return)) |-> (status_word == ($past(exc_return_sr) & 16'hA71F)));

    // R7: no acceptance alongside a strobe
    p_strobe_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(exc_return || sr_load)) |-> !take);

    // R8: unimplemented bits stay zero
    p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word & 16'h58E0) == 16'h0000);
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .boundary      (boundary),
    .sr_load       (sr_load),
    .exc_return    (exc_return),
    .exc_return_sr (exc_return_sr),
    .status_word   (status_word),
    .take          (take),
    .take_level    (take_level),
    .take_vec_addr (take_vec_addr)
);

// File: tb/test_irq_level_ctrl.sv
`timescale 1ns/1ps
// Bench for irq_level_ctrl: reset, mask x level sweep, exhaustive 4-source
// priority sweep, level-7 edge behaviour, boundary gating and strobes.
module test_irq_level_ctrl;
    localparam int NS = 4;
    localparam int VW = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NS*3-1:0]   src_level;
    logic [NS*VW-1:0]  src_vector;
    logic              boundary;
    logic              sr_load;
    logic [15:0]       sr_load_data;
    logic              exc_return;
    logic [15:0]       exc_return_sr;
    logic [15:0]       status_word;
    logic              take;
    logic [2:0]        take_level;
    logic [VW+1:0]     take_vec_addr;
    logic [15:0]       take_saved_sr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    irq_level_ctrl #(.N_SRC(NS), .VEC_W(VW)) i_irq_level_ctrl (
        .clk(clk), .rst_n(rst_n), .src_level(src_level), .src_vector(src_vector),
        .boundary(boundary), .sr_load(sr_load), .sr_load_data(sr_load_data),
        .exc_return(exc_return), .exc_return_sr(exc_return_sr),
        .status_word(status_word), .take(take), .take_level(take_level),
        .take_vec_addr(take_vec_addr), .take_saved_sr(take_saved_sr)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] vec_of(input int s);
        return 8'(64 + 45 * s);
    endfunction

    // Load a status word, then present one request pattern for one cycle.
    task automatic trial(input logic [15:0] w, input logic [NS*3-1:0] lv, input logic bnd);
        @(negedge clk);
        sr_load = 1'b1; sr_load_data = w; src_level = '0; boundary = 1'b0;
        @(negedge clk);
        sr_load = 1'b0; src_level = lv; boundary = bnd;
        @(negedge clk);
    endtask

    task automatic idle();
        src_level = '0; boundary = 1'b0; sr_load = 1'b0; exc_return = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        idle();
        sr_load_data = '0; exc_return_sr = '0;
        for (int s = 0; s < NS; s++) src_vector[s*VW +: VW] = vec_of(s);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 status", 32'(status_word), 32'h2700);
        check("R1 take", 32'(take), 0);
        rst_n = 1'b1;

        // R3 R4 R5: every mask against every level on a single source
        for (int m = 0; m < 8; m++) begin
            for (int l = 1; l < 8; l++) begin
                logic [15:0] w;
                logic [NS*3-1:0] lv;
                bit exp_take;
                w = 16'h8000 | 16'(m << 8) | 16'(l & 5'h1F);
                lv = '0;
                lv[(l % NS)*3 +: 3] = 3'(l);
                exp_take = (l == 7) || (l > m);
                trial(w, lv, 1'b1);
                check(exp_take ? "R5 take" : "R3 no take", 32'(take), 32'(exp_take));
                if (exp_take) begin
                    check("R5 level", 32'(take_level), 32'(l));
                    check("R5 status", 32'(status_word), 32'((w & 16'hF8FF) | 16'h2000 | 16'(l << 8)));
                    check("R5 saved", 32'(take_saved_sr), 32'(w));
                end else begin
                    check("R3 status kept", 32'(status_word), 32'(w));
                end
                idle();
            end
        end

        // R2 R6: exhaustive levels across four sources, mask 0
        for (int code = 0; code < 4096; code++) begin
            int bl, bs;
            bl = 0; bs = 0;
            for (int s = 0; s < NS; s++) begin
                int lvs;
                lvs = (code >> (3*s)) & 7;
                if (lvs > bl) begin bl = lvs; bs = s; end
            end
            trial(16'h0000, 12'(code), 1'b1);
            check("R2 take", 32'(take), 32'(bl != 0));
            if (bl != 0) begin
                check("R2 level", 32'(take_level), 32'(bl));
                check("R6 vec addr", 32'(take_vec_addr), 32'(vec_of(bs)) * 4);
            end
            idle();
        end

        // R4: held level 7 taken once, re-taken after a gap
        trial(16'h2700, 12'h007, 1'b1);
        check("R4 first", 32'(take), 1);
        @(negedge clk);
        check("R4 held no retake", 32'(take), 0);
        @(negedge clk);
        check("R4 held no retake 2", 32'(take), 0);
        src_level = '0;
        @(negedge clk);
        src_level = 12'h007;
        @(negedge clk);
        check("R4 retake after gap", 32'(take), 1);
        check("R4 level", 32'(take_level), 7);
        idle();

        // R4: arrival with boundary low is remembered
        @(negedge clk);
        src_level = 12'h007; boundary = 1'b0;
        @(negedge clk);
        check("R4 wait boundary", 32'(take), 0);
        boundary = 1'b1;
        @(negedge clk);
        check("R4 pending taken", 32'(take), 1);
        idle();

        // R9: boundary low blocks a maskable request
        trial(16'h0000, 12'h005, 1'b0);
        check("R9 no take", 32'(take), 0);
        check("R9 status", 32'(status_word), 0);
        idle();

        // R7 R8: return wins over write and blocks acceptance
        @(negedge clk);
        exc_return = 1'b1; exc_return_sr = 16'hFFFF;
        sr_load = 1'b1; sr_load_data = 16'h0000;
        src_level = 12'h007; boundary = 1'b1;
        @(negedge clk);
        check("R7 restore", 32'(status_word), 32'hA71F);
        check("R7 blocked", 32'(take), 0);
        idle();
        @(negedge clk);
        sr_load = 1'b1; sr_load_data = 16'hFFFF;
        @(negedge clk);
        check("R8 unused zero", 32'(status_word), 32'hA71F);
        sr_load = 1'b0; exc_return = 1'b1; exc_return_sr = 16'h0005;
        @(negedge clk);
        check("R7 restore user", 32'(status_word), 32'h0005);
        idle();
        @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule